// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This block takes two 64-bit IEEE-754 double-precision operands and evaluates one of four relations between them: equal, less than, less or equal, and unordered. A two-bit operation code picks the relation. Each operand is first sorted into one of six classes: signaling NaN, quiet NaN, infinity, zero, subnormal or normal. The relation is then decided from the two classes, the two signs and the ordering of the two magnitudes.

The answer is given as a full 64-bit word rather than a single bit. A true relation gives the double value 2.0 and a false relation gives all zeros, so the word can be written straight into a floating-point register. An invalid-operation flag comes with the answer. The decision logic is purely combinational. The answer, the flag and a valid pulse are registered one clock after an input strobe. Without a strobe, the answer and the flag hold their last values.

Top module: `fp64_cmp_unit`

## Requirements
- R1: While reset is active, and on the first clock after it, out_valid, result and invalid_flag are all zero.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. result and invalid_flag load only on a strobed cycle and keep their values otherwise, whatever the operand inputs do.
- R3: The operation code selects the relation: 00 equal, 01 less than, 10 less or equal, 11 unordered. A true answer is 0x4000000000000000 and a false answer is 0x0000000000000000.
- R4: A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 51 clear. If either operand is a signaling NaN, invalid_flag is set, and the equal, less-than and less-or-equal relations answer false.
- R5: A quiet NaN has an all-ones exponent and fraction bit 51 set. If either operand is a quiet NaN and neither is a signaling NaN, the equal, less-than and less-or-equal relations answer false and invalid_flag stays clear.
- R6: The unordered relation answers true when either operand is any NaN and false otherwise. It raises invalid_flag only when a signaling NaN is present.
- R7: Positive and negative zero compare equal in any combination. Less than is false for every pair of zeros, and less or equal is true for every pair of zeros.
- R8: A negative non-NaN operand is less than a positive non-NaN operand unless both are zeros. The reverse order is never less than.
- R9: Two positive operands are ordered by exponent and then by fraction. Subnormals lie below normals, and positive infinity lies above the largest finite value.
- R10: Two negative operands are ordered the opposite way: the one with the larger exponent, or the same exponent and a larger fraction, is the lesser.
- R11: invalid_flag is never set when neither operand is a NaN. This includes infinities and subnormals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: operands and op_sel are taken this cycle |
| op_sel | input | 2 | Relation select: 00 eq, 01 lt, 10 le, 11 unordered |
| opnd_a | input | 64 | Left operand, IEEE double |
| opnd_b | input | 64 | Right operand, IEEE double |
| out_valid | output | 1 | High one cycle after a strobe |
| result | output | 64 | 2.0 encoding when true, zero when false |
| invalid_flag | output | 1 | Invalid-operation indication for the last strobe |

## Verification
The unordered relation with a signaling NaN operand is the one case where a true answer and the invalid flag fall in the same registered sample. Every other invalid case returns false. The vector table places a signaling NaN in the left slot, in the right slot, and next to a quiet NaN, under the unordered code and under the ordering codes. Each vector checks the result word and the flag together in the cycle after the strobe. Only the pairing of a true 2.0 word with the raised flag passes for unordered, and only a zero word with the raised flag passes for the other codes.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // operand class, signaling NaN first so NaN tests are a simple range
  typedef enum logic [2:0] {
    CLS_SNAN = 3'd0,
    CLS_QNAN = 3'd1,
    CLS_INF  = 3'd2,
    CLS_ZERO = 3'd3,
    CLS_SUB  = 3'd4,
    CLS_NORM = 3'd5
  } fp_class_e;

  // relation select; the encoding is visible on op_sel
  typedef enum logic [1:0] {
    PRED_EQ = 2'b00,
    PRED_LT = 2'b01,
    PRED_LE = 2'b10,
    PRED_UN = 2'b11
  } pred_e;

  function automatic logic is_nan(input fp_class_e c);
    return (c == CLS_SNAN) || (c == CLS_QNAN);
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output fp_class_e               cls
);

  localparam int MAG_W = EXP_W + FRAC_W;

  function automatic fp_class_e sort_class(input logic [MAG_W-1:0] m);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = m[MAG_W-1:FRAC_W];
    f = m[FRAC_W-1:0];
    if (e == '1) begin
      if (f == '0)          return CLS_INF;
      else if (f[FRAC_W-1]) return CLS_QNAN;
      else                  return CLS_SNAN;
    end else if (e == '0) begin
      return (f == '0) ? CLS_ZERO : CLS_SUB;
    end
    return CLS_NORM;
  endfunction

  assign cls = sort_class(mag);

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MAG_W = 63
) (
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             a_below,
  output logic             a_same
);

  // biased exponent above fraction makes the raw magnitude field
  // order exactly like the value, subnormals and infinity included
  function automatic logic [1:0] mag_order(input logic [MAG_W-1:0] x,
                                           input logic [MAG_W-1:0] y);
    return {x < y, x == y};
  endfunction

  assign {a_below, a_same} = mag_order(mag_a, mag_b);

endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
  import fpcmp_pkg::*;
(
  input  fp_class_e cls_a,
  input  fp_class_e cls_b,
  input  logic      sign_a,
  input  logic      sign_b,
  input  logic      a_below,
  input  logic      a_same,
  input  pred_e     pred,
  output logic      hit,
  output logic      flag
);

  logic any_snan, any_nan, both_zero;
  logic rel_eq, rel_lt, a_above;

  assign any_snan  = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  assign any_nan   = is_nan(cls_a) || is_nan(cls_b);
  assign both_zero = (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO);
  assign a_above   = !a_below && !a_same;

  assign rel_eq = both_zero || ((sign_a == sign_b) && a_same);
  assign rel_lt = !both_zero &&
                  (( sign_a && !sign_b) ||
                   ( sign_a &&  sign_b && a_above) ||
                   (!sign_a && !sign_b && a_below));

  always_comb begin
    unique case (pred)
      PRED_EQ: hit = !any_nan && rel_eq;
      PRED_LT: hit = !any_nan && rel_lt;
      PRED_LE: hit = !any_nan && (rel_eq || rel_lt);
      default: hit = any_nan;
    endcase
  end

  assign flag = any_snan;

endmodule

// File: rtl/fp64_cmp_unit.sv
module fp64_cmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             op_sel,
  input  logic [EXP_W+FRAC_W:0]  opnd_a,
  input  logic [EXP_W+FRAC_W:0]  opnd_b,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   invalid_flag
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = WORD_W - 1;
  // value 2.0: biased exponent equal to bias + 1, fraction zero
  localparam logic [WORD_W-1:0] TRUE_WORD = {2'b01, {(WORD_W-2){1'b0}}};

  logic [WORD_W-1:0] opnd [2];
  fp_class_e         cls_v [2];
  fp_class_e         cls_a, cls_b;
  logic              a_below, a_same;
  logic              hit_w, flag_w;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag (opnd[gi][MAG_W-1:0]),
      .cls (cls_v[gi])
    );
  end

  assign cls_a = cls_v[0];
  assign cls_b = cls_v[1];

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .mag_a   (opnd_a[MAG_W-1:0]),
    .mag_b   (opnd_b[MAG_W-1:0]),
    .a_below (a_below),
    .a_same  (a_same)
  );

  fpcmp_decide u_decide (
    .cls_a   (cls_a),
    .cls_b   (cls_b),
    .sign_a  (opnd_a[WORD_W-1]),
    .sign_b  (opnd_b[WORD_W-1]),
    .a_below (a_below),
    .a_same  (a_same),
    .pred    (pred_e'(op_sel)),
    .hit     (hit_w),
    .flag    (flag_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= hit_w ? TRUE_WORD : '0;
        invalid_flag <= flag_w;
      end
    end
  end

endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
  import fpcmp_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input fp_class_e         cls_a,
  input fp_class_e         cls_b,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              invalid_flag
);

  localparam logic [WORD_W-1:0] TRUE_WORD = {2'b01, {(WORD_W-2){1'b0}}};

  // R1: reset clears the registered outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0 && !invalid_flag));

  // R2: valid pulse follows the strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: outputs hold without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid_flag)));

  // R3: only the two legal codes appear
  a_r3_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result == '0 || result == TRUE_WORD));

  // R4: signaling NaN raises the flag
  a_r4_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cls_a == CLS_SNAN || cls_b == CLS_SNAN)) |=> invalid_flag);

  // R4, R5: ordering relations with a NaN are false
  a_r5_nan_false: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel != 2'b11 && (is_nan(cls_a) || is_nan(cls_b)))
      |=> (result == '0));

  // R6: unordered is true for any NaN
  a_r6_unordered_true: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11 && (is_nan(cls_a) || is_nan(cls_b)))
      |=> (result == TRUE_WORD));

  // R7: less than over two zeros is false
  a_r7_zero_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01 && cls_a == CLS_ZERO && cls_b == CLS_ZERO)
      |=> (result == '0));

  // R11: no flag without a signaling NaN
  a_r11_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_a != CLS_SNAN && cls_b != CLS_SNAN) |=> !invalid_flag);

endmodule

bind fp64_cmp_unit fpcmp_checker #(.WORD_W(WORD_W)) u_fpcmp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_sel       (op_sel),
  .cls_a        (cls_a),
  .cls_b        (cls_b),
  .out_valid    (out_valid),
  .result       (result),
  .invalid_flag (invalid_flag)
);

// File: tb/test_fp64_cmp_unit.sv
`timescale 1ns/1ps
module test_fp64_cmp_unit;

  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] ONEP = 64'h3FF0000000000001;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] NONE = 64'hBFF0000000000000;
  localparam logic [63:0] NTWO = 64'hC000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN   = 64'h7FF8000000000000;
  localparam logic [63:0] SN   = 64'h7FF0000000000001;
  localparam logic [63:0] NSN  = 64'hFFF4000000000000;
  localparam logic [63:0] DEN  = 64'h0000000000000001;
  localparam logic [63:0] MAXN = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] TRUE_W = 64'h4000000000000000;

  localparam logic [1:0] OP_EQ = 2'b00, OP_LT = 2'b01, OP_LE = 2'b10, OP_UN = 2'b11;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic        t;
    logic        inv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_EQ, ONE,  ONE,  1'b1, 1'b0, 8'd3},   // R3
    '{OP_EQ, ONE,  ONEP, 1'b0, 1'b0, 8'd3},   // R3
    '{OP_EQ, PZ,   NZ,   1'b1, 1'b0, 8'd7},   // R7
    '{OP_LT, PZ,   NZ,   1'b0, 1'b0, 8'd7},   // R7
    '{OP_LT, NZ,   PZ,   1'b0, 1'b0, 8'd7},   // R7
    '{OP_LE, NZ,   PZ,   1'b1, 1'b0, 8'd7},   // R7
    '{OP_LT, NONE, ONE,  1'b1, 1'b0, 8'd8},   // R8
    '{OP_LT, ONE,  NONE, 1'b0, 1'b0, 8'd8},   // R8
    '{OP_LT, ONE,  TWO,  1'b1, 1'b0, 8'd9},   // R9
    '{OP_LT, ONE,  ONEP, 1'b1, 1'b0, 8'd9},   // R9
    '{OP_LT, DEN,  ONE,  1'b1, 1'b0, 8'd9},   // R9
    '{OP_LT, PZ,   DEN,  1'b1, 1'b0, 8'd9},   // R9
    '{OP_LT, MAXN, PINF, 1'b1, 1'b0, 8'd9},   // R9
    '{OP_LT, NTWO, NONE, 1'b1, 1'b0, 8'd10},  // R10
    '{OP_LT, NONE, NTWO, 1'b0, 1'b0, 8'd10},  // R10
    '{OP_LE, NONE, NONE, 1'b1, 1'b0, 8'd10},  // R10
    '{OP_LE, TWO,  ONE,  1'b0, 1'b0, 8'd9},   // R9
    '{OP_LT, NINF, NONE, 1'b1, 1'b0, 8'd10},  // R10
    '{OP_EQ, PINF, PINF, 1'b1, 1'b0, 8'd11},  // R11
    '{OP_EQ, QN,   QN,   1'b0, 1'b0, 8'd5},   // R5
    '{OP_LT, QN,   ONE,  1'b0, 1'b0, 8'd5},   // R5
    '{OP_LE, ONE,  QN,   1'b0, 1'b0, 8'd5},   // R5
    '{OP_EQ, SN,   ONE,  1'b0, 1'b1, 8'd4},   // R4
    '{OP_LE, ONE,  NSN,  1'b0, 1'b1, 8'd4},   // R4
    '{OP_LT, QN,   SN,   1'b0, 1'b1, 8'd4},   // R4
    '{OP_UN, QN,   ONE,  1'b1, 1'b0, 8'd6},   // R6
    '{OP_UN, ONE,  SN,   1'b1, 1'b1, 8'd6},   // R6
    '{OP_UN, ONE,  TWO,  1'b0, 1'b0, 8'd6},   // R6
    '{OP_UN, PINF, NINF, 1'b0, 1'b0, 8'd11}   // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp64_cmp_unit i_fp64_cmp_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_sel       (op_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, sample at the next falling edge
  task automatic strobe(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check64("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check64("R1 result", result, 64'd0);
    check64("R1 invalid", {63'd0, invalid_flag}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i].op, VECS[i].a, VECS[i].b);
      check64($sformatf("R%0d vec%0d result", VECS[i].req, i), result,
              VECS[i].t ? TRUE_W : 64'd0);
      check64($sformatf("R%0d vec%0d invalid", VECS[i].req, i),
              {63'd0, invalid_flag}, {63'd0, VECS[i].inv});
      check64("R2 valid pulse", {63'd0, out_valid}, 64'd1);
    end

    // R2: valid drops, outputs hold while inputs change without strobe
    strobe(OP_UN, SN, ONE);
    @(negedge clk);
    check64("R2 valid low", {63'd0, out_valid}, 64'd0);
    op_sel = OP_EQ; opnd_a = ONE; opnd_b = TWO;
    repeat (3) @(negedge clk);
    check64("R2 result held", result, TRUE_W);
    check64("R2 flag held", {63'd0, invalid_flag}, 64'd1);

    // R3: back to back strobes, each answer one cycle later
    @(negedge clk);
    op_sel = OP_LE; opnd_a = TWO; opnd_b = TWO; in_valid = 1'b1;
    @(negedge clk);
    check64("R3 b2b first", result, TRUE_W);
    op_sel = OP_LT; opnd_a = TWO; opnd_b = ONE;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R3 b2b second", result, 64'd0);
    check64("R11 b2b flag", {63'd0, invalid_flag}, 64'd0);

    // R1: reset in mid run clears loaded outputs
    strobe(OP_EQ, PZ, NZ);
    rst_n = 1'b0;
    @(negedge clk);
    check64("R1 mid reset result", result, 64'd0);
    check64("R1 mid reset valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule